// File: doc/BRIEF.md
# Memory-fed waveform word sequencer

This block sits beside a bank of pulse-width channels and turns each one from a statically programmed generator into a player of a waveform table held in memory. Every table entry is a 32-bit word giving the high count (bits 31:16) and low count (bits 15:0) for one output period. The word is passed through to the waveform channel without being changed. For each channel, software programs a byte start address and a table length in words. It then enables the channel, selects table-driven updates, and writes a trigger bit.

From then on the channel's fetch engine reads the table into an 8-entry FIFO, four words at a time, over a simple single-outstanding read port. The waveform channel signals the end of each period, and at that point the sequencer presents the next FIFO entry. At the end of the table the engine either starts again from the start address (loop mode) or stops and raises a per-channel end status. Unmasked status bits combine into one active-high interrupt.

Register map (word addresses on the write port): 0 enable-set, 1 enable-clear, 2 update-mode select, 3 loop select, 4 trigger, 5 status clear, 6 interrupt mask. Channel c owns addresses 8+4c (start address), 9+4c (length) and 10+4c (static waveform word). In the bit-per-channel registers, bit c belongs to channel c.

Top module: `wave_stream_dma`

## Requirements
- R1: With mode bit c at 0 (address 2), wave word c equals the static word written at address 10+4c, and end-of-period pulses leave it unchanged.
- R2: Writing 1s to address 0 sets enable bits and writing 1s to address 1 clears them, as seen on en_o. Clearing a channel aborts its transfer: busy_o goes low and empty_o goes high on the next cycle.
- R3: A trigger write (address 4, bit c) starts channel c only if it is enabled, has mode bit 1 and is idle. busy_o[c] is high from the cycle after the accepted write. A trigger that is not accepted has no effect.
- R4: Word i of a transfer is read from byte address start+4i. The read port carries at most one request at a time, and each request lasts a single cycle.
- R5: A burst of 4 reads begins only when the FIFO holds at most 4 entries, so the 8-entry FIFO never overflows. empty_o[c] is high exactly when the FIFO of channel c holds no entry.
- R6: In table mode, an end-of-period pulse pops one FIFO entry, and that entry appears on the wave word in the following cycle.
- R7: A pulse that arrives while the FIFO is empty leaves the wave word at its last value.
- R8: Without loop, busy_o[c] falls in the cycle the last table word has been fetched, and status bit c is set in that same cycle.
- R9: With loop bit c set (address 3), the fetch restarts from the start address after the last word. The transfer stays busy and raises no status.
- R10: Writing 1 to bit c of address 5 clears status bit c.
- R11: irq_o is the OR of the status bits whose mask bit (address 6) is 0. A mask bit of 1 blocks its channel.
- R12: The length register ignores its two low bits. A length of 0 finishes at once and sets status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register word address |
| wr_data_i | input | 32 | Register write data |
| period_done_i | input | NCH | End-of-period pulse per channel |
| mem_req_o | output | NCH | Single-cycle read request per channel |
| mem_addr_o | output | NCH*32 | Byte read address per channel |
| mem_rvalid_i | input | NCH | Read data valid per channel |
| mem_rdata_i | input | NCH*32 | Read data per channel |
| wave_o | output | NCH*32 | Current waveform word per channel |
| en_o | output | NCH | Enable bits |
| busy_o | output | NCH | Fetch engine active |
| empty_o | output | NCH | FIFO empty |
| status_o | output | NCH | End-of-transfer status |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
A wrong address pointer or a bad FIFO pointer shows up on the wave word at the very next end-of-period pulse, as a value that does not match the arithmetic table pattern. The bench compares every popped word across several lengths, both channels and a wrapped loop. A miscounted remaining-length register shows up a few cycles after the final fetch, as busy and status bits that are wrong. A stuck state machine shows up at once on the trigger and abort edges through busy_o and empty_o.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  localparam int unsigned REG_EN_SET   = 0;
  localparam int unsigned REG_EN_CLR   = 1;
  localparam int unsigned REG_MODE     = 2;
  localparam int unsigned REG_LOOP     = 3;
  localparam int unsigned REG_TRIG     = 4;
  localparam int unsigned REG_STAT_CLR = 5;
  localparam int unsigned REG_MASK     = 6;
  localparam int unsigned CH_BASE      = 8;
  localparam int unsigned CH_STRIDE    = 4;
  localparam int unsigned OFF_START    = 0;
  localparam int unsigned OFF_LEN      = 1;
  localparam int unsigned OFF_STATIC   = 2;

  typedef enum logic [1:0] {FS_IDLE, FS_RUN, FS_REQ, FS_WAIT} fetch_state_e;
endpackage

// File: rtl/wsd_fifo.sv
module wsd_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,   // power of two
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH)) && !flush_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/wsd_fetch.sv
module wsd_fetch
  import wsd_pkg::*;
#(
  parameter int unsigned MADDR_W    = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned BURST      = 4,
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned BW = $clog2(BURST + 1),
  localparam int unsigned WORD_BYTES = WORD_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               loop_i,
  input  logic               pop_i,
  input  logic [MADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               mem_rvalid_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic               busy_o,
  output logic               empty_o,
  output logic               done_o,
  output logic [WORD_W-1:0]  word_o
);
  fetch_state_e state_q;
  logic [MADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]   rem_q, len_w;
  logic [BW-1:0]      burst_q;
  logic [WORD_W-1:0]  cur_q, head;
  logic [CW-1:0]      cnt;
  logic room, push, pop_ok, wrap;

  assign len_w  = len_i & ~LEN_W'(3);
  assign room   = cnt <= CW'(FIFO_DEPTH - BURST);
  assign wrap   = loop_i && (len_w != '0);
  assign push   = (state_q == FS_WAIT) && mem_rvalid_i && !abort_i;
  assign pop_ok = pop_i && (cnt != '0) && !abort_i && !start_i;
  assign done_o = (state_q == FS_RUN) && (rem_q == '0) && !wrap && !abort_i;

  wsd_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (start_i || abort_i),
    .push_i  (push),
    .wdata_i (mem_rdata_i),
    .pop_i   (pop_ok),
    .rdata_o (head),
    .count_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      burst_q <= '0;
    end else if (abort_i) begin
      state_q <= FS_IDLE;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          state_q <= FS_RUN;
          ptr_q   <= base_i;
          rem_q   <= len_w;
        end
        FS_RUN: begin
          if (rem_q == '0) begin
            if (wrap) begin
              ptr_q <= base_i;
              rem_q <= len_w;
            end else begin
              state_q <= FS_IDLE;
            end
          end else if (room) begin
            state_q <= FS_REQ;
            burst_q <= BW'(BURST);
          end
        end
        FS_REQ: state_q <= FS_WAIT;
        FS_WAIT: if (mem_rvalid_i) begin
          ptr_q   <= ptr_q + MADDR_W'(WORD_BYTES);
          rem_q   <= rem_q - 1'b1;
          burst_q <= burst_q - 1'b1;
          state_q <= (burst_q == BW'(1)) ? FS_RUN : FS_REQ;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (pop_ok) cur_q <= head;
  end

  assign mem_req_o  = (state_q == FS_REQ);
  assign mem_addr_o = ptr_q;
  assign busy_o     = (state_q != FS_IDLE);
  assign empty_o    = (cnt == '0);
  assign word_o     = cur_q;
endmodule

// File: rtl/wave_stream_dma.sv
module wave_stream_dma
  import wsd_pkg::*;
#(
  parameter int unsigned NCH        = 2,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MADDR_W    = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned BURST      = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [NCH-1:0]         period_done_i,
  output logic [NCH-1:0]         mem_req_o,
  output logic [NCH*MADDR_W-1:0] mem_addr_o,
  input  logic [NCH-1:0]         mem_rvalid_i,
  input  logic [NCH*WORD_W-1:0]  mem_rdata_i,
  output logic [NCH*WORD_W-1:0]  wave_o,
  output logic [NCH-1:0]         en_o,
  output logic [NCH-1:0]         busy_o,
  output logic [NCH-1:0]         empty_o,
  output logic [NCH-1:0]         status_o,
  output logic                   irq_o
);
  logic [NCH-1:0] en_q, mode_q, loop_q, mask_q, status_q;
  logic [NCH-1:0] trig, abort, done;
  logic wr_en_set, wr_en_clr, wr_mode, wr_loop, wr_trig, wr_sclr, wr_mask;

  assign wr_en_set = wr_en_i && (wr_addr_i == ADDR_W'(REG_EN_SET));
  assign wr_en_clr = wr_en_i && (wr_addr_i == ADDR_W'(REG_EN_CLR));
  assign wr_mode   = wr_en_i && (wr_addr_i == ADDR_W'(REG_MODE));
  assign wr_loop   = wr_en_i && (wr_addr_i == ADDR_W'(REG_LOOP));
  assign wr_trig   = wr_en_i && (wr_addr_i == ADDR_W'(REG_TRIG));
  assign wr_sclr   = wr_en_i && (wr_addr_i == ADDR_W'(REG_STAT_CLR));
  assign wr_mask   = wr_en_i && (wr_addr_i == ADDR_W'(REG_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      mode_q   <= '0;
      loop_q   <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_en_set) en_q <= en_q | wr_data_i[NCH-1:0];
      if (wr_en_clr) en_q <= en_q & ~wr_data_i[NCH-1:0];
      if (wr_mode)   mode_q <= wr_data_i[NCH-1:0];
      if (wr_loop)   loop_q <= wr_data_i[NCH-1:0];
      if (wr_mask)   mask_q <= wr_data_i[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (done[c])                     status_q[c] <= 1'b1;
        else if (wr_sclr && wr_data_i[c]) status_q[c] <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + c * CH_STRIDE;
    logic [MADDR_W-1:0] start_q;
    logic [LEN_W-1:0]   len_q;
    logic [WORD_W-1:0]  static_q, cur;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q  <= '0;
        len_q    <= '0;
        static_q <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(BASE + OFF_START))  start_q  <= MADDR_W'(wr_data_i);
        if (wr_addr_i == ADDR_W'(BASE + OFF_LEN))    len_q    <= LEN_W'(wr_data_i);
        if (wr_addr_i == ADDR_W'(BASE + OFF_STATIC)) static_q <= WORD_W'(wr_data_i);
      end
    end

    assign trig[c]  = wr_trig && wr_data_i[c] && en_q[c] && mode_q[c] && !busy_o[c];
    assign abort[c] = wr_en_clr && wr_data_i[c];

    wsd_fetch #(
      .MADDR_W(MADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W),
      .FIFO_DEPTH(FIFO_DEPTH), .BURST(BURST)
    ) u_fetch (
      .clk_i, .rst_ni,
      .start_i      (trig[c]),
      .abort_i      (abort[c]),
      .loop_i       (loop_q[c]),
      .pop_i        (period_done_i[c] && mode_q[c]),
      .base_i       (start_q),
      .len_i        (len_q),
      .mem_rvalid_i (mem_rvalid_i[c]),
      .mem_rdata_i  (mem_rdata_i[c*WORD_W +: WORD_W]),
      .mem_req_o    (mem_req_o[c]),
      .mem_addr_o   (mem_addr_o[c*MADDR_W +: MADDR_W]),
      .busy_o       (busy_o[c]),
      .empty_o      (empty_o[c]),
      .done_o       (done[c]),
      .word_o       (cur)
    );

    assign wave_o[c*WORD_W +: WORD_W] = mode_q[c] ? cur : static_q;
  end

  assign en_o     = en_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & ~mask_q);
endmodule

// File: rtl/wave_stream_dma_chk.sv
module wave_stream_dma_chk
  import wsd_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [NCH-1:0]        wr_bits_i,
  input logic [NCH-1:0]        period_done_i,
  input logic [NCH-1:0]        mem_req_o,
  input logic [NCH-1:0]        busy_o,
  input logic [NCH-1:0]        status_o,
  input logic [NCH*WORD_W-1:0] wave_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4: single-cycle request, never two in a row
    p_single_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o[c] |=> !mem_req_o[c]);
    // R4: requests only from an active engine
    p_req_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o[c] |-> busy_o[c]);
    // R3: busy only rises after a trigger write
    p_start_trig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o[c]) |->
        $past(wr_en_i && (wr_addr_i == ADDR_W'(REG_TRIG)) && wr_bits_i[c]));
    // R8: status is raised with the end of fetching
    p_status_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[c]) |-> $fell(busy_o[c]));
    // R10: status only drops after a clear write
    p_status_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[c]) |->
        $past(wr_en_i && (wr_addr_i == ADDR_W'(REG_STAT_CLR)) && wr_bits_i[c]));
    // R6: the wave word moves only on a pulse or a register write
    p_wave_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(period_done_i[c]) && !$past(wr_en_i)) |->
        $stable(wave_o[c*WORD_W +: WORD_W]));
  end
endmodule

bind wave_stream_dma wave_stream_dma_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_bits_i     (wr_data_i[NCH-1:0]),
  .period_done_i (period_done_i),
  .mem_req_o     (mem_req_o),
  .busy_o        (busy_o),
  .status_o      (status_o),
  .wave_o        (wave_o)
);

// File: tb/wave_stream_dma_bench.sv
module wave_stream_dma_bench;
  localparam int NCH = 2;
  localparam logic [5:0] A_EN_SET = 6'd0, A_EN_CLR = 6'd1, A_MODE = 6'd2, A_LOOP = 6'd3,
                         A_TRIG = 6'd4, A_SCLR = 6'd5, A_MASK = 6'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0] pd = '0;
  logic [NCH-1:0] req, rvalid = '0;
  logic [NCH*32-1:0] maddr, rdata = '0, wave;
  logic [NCH-1:0] en, busy, empty, status;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wave_stream_dma u_wave_stream_dma (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .period_done_i(pd), .mem_req_o(req), .mem_addr_o(maddr), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .wave_o(wave), .en_o(en), .busy_o(busy), .empty_o(empty),
    .status_o(status), .irq_o(irq)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[17:2] + 16'h0101};
  endfunction

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      rvalid[c] <= req[c];
      rdata[c*32 +: 32] <= memf(maddr[c*32 +: 32]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop(input int c);
    @(negedge clk); pd[c] = 1'b1;
    @(negedge clk); pd[c] = 1'b0;
  endtask

  function automatic logic [31:0] wv(input int c);
    return wave[c*32 +: 32];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("reset en", 32'(en), 0);
    chk("reset busy", 32'(busy), 0);
    chk("reset empty", 32'(empty), 3);
    chk("reset status/irq", {31'(status), irq}, 0);
    chk("reset wave", wv(0), 0);

    // R1 static word, pulses ignored
    wr(6'd10, 32'h0064_0032);
    chk("R1 static word", wv(0), 32'h0064_0032);
    pop(0);
    chk("R1 pulse ignored", wv(0), 32'h0064_0032);

    // R3 trigger while disabled ignored
    wr(A_MODE, 32'h3);
    wr(6'd8, 32'h100); wr(6'd9, 32'd4);
    wr(A_TRIG, 32'h1);
    @(negedge clk);
    chk("R3 trigger disabled ignored", 32'(busy), 0);

    // R2 enable set
    wr(A_EN_SET, 32'h3);
    chk("R2 enable set", 32'(en), 3);

    // sweep channels and lengths, non-loop
    for (int c = 0; c < NCH; c++) begin
      for (int len = 4; len <= 16; len += 4) begin
        logic m;
        m = (len == 8 || len == 16);
        base = 32'h1000 + 32'(c) * 32'h400 + 32'(len) * 32'h40;
        wr(6'(8 + 4*c), base);
        wr(6'(9 + 4*c), 32'(len) | (c == 1 ? 32'h3 : 32'h0)); // R12 low bits ignored
        wr(A_MASK, m ? (32'h1 << c) : 32'h0);
        wr(A_TRIG, 32'h1 << c);
        chk($sformatf("R3 busy after trigger ch%0d len%0d", c, len), 32'(busy[c]), 1);
        repeat (16) @(negedge clk);
        chk("R5 fifo filled", 32'(empty[c]), 0);
        for (int i = 0; i < len; i++) begin
          repeat (16) @(negedge clk);
          pop(c);
          chk($sformatf("R4 R6 ch%0d len%0d word%0d", c, len, i), wv(c), memf(base + 32'(4*i)));
        end
        repeat (4) @(negedge clk);
        chk("R8 busy low at end", 32'(busy[c]), 0);
        chk("R5 empty at end", 32'(empty[c]), 1);
        chk("R8 status set", 32'(status[c]), 1);
        chk("R11 irq vs mask", 32'(irq), m ? 0 : 1);
        w = wv(c);
        pop(c);
        chk("R7 hold last word", wv(c), w);
        wr(A_SCLR, 32'h1 << c);
        chk("R10 status cleared", 32'(status[c]), 0);
      end
    end

    // R9 loop on channel 1
    base = 32'h3000;
    wr(6'd12, base); wr(6'd13, 32'd8);
    wr(A_LOOP, 32'h2);
    wr(A_TRIG, 32'h2);
    for (int i = 0; i < 20; i++) begin
      repeat (16) @(negedge clk);
      pop(1);
      chk($sformatf("R9 loop word%0d", i), wv(1), memf(base + 32'(4*(i % 8))));
    end
    chk("R9 loop still busy", 32'(busy[1]), 1);
    chk("R9 loop no status", 32'(status[1]), 0);

    // R2 abort
    wr(A_EN_CLR, 32'h2);
    chk("R2 abort busy", 32'(busy[1]), 0);
    chk("R2 abort empty", 32'(empty[1]), 1);
    chk("R2 enable cleared", 32'(en), 1);

    // R12 length zero, R11 masking
    wr(A_LOOP, 32'h0);
    wr(A_MASK, 32'h1);
    wr(6'd9, 32'h3);
    wr(A_TRIG, 32'h1);
    @(negedge clk);
    chk("R12 zero length status", 32'(status[0]), 1);
    chk("R12 zero length idle", 32'(busy[0]), 0);
    chk("R11 masked irq", 32'(irq), 0);
    wr(A_MASK, 32'h0);
    chk("R11 unmasked irq", 32'(irq), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule